// File: doc/BRIEF.md
# Interruption Priority Selector and Status-Word Swapper

This block decides which pending interruption a processor core takes next and then performs the status-word exchange for it. It holds the pending sources itself. These are one exception slot (a program exception or a supervisor call), a last-in first-out stack of external requests, a clock-comparator flag and a CPU-timer flag. On a `start` pulse it compares them by priority. For the winning class it writes the interruption code, any parameter and the old status word (mask and address) into that class's slot of a save area in memory. It then reads the new status word from the same slot and presents it on its outputs.

Memory is reached through a single word port: one read or one write per cycle, with read data returned one cycle after the read. The current status word, the condition code and the CPU number are inputs. They are sampled in the cycle of `start`. Each class owns an 8-word slot starting at `BASE + slot*8`, where slot 0 is program, slot 1 is supervisor call and slot 2 is external. Within a slot:
- word 0 holds the code word;
- word 1 holds the external parameter;
- word 2 holds the old mask;
- word 3 holds the old address;
- word 4 holds the new mask;
- word 5 holds the new address;
- word 6 holds the CPU address word.

Top module: `intr_swap`

## Requirements
- R1: With an exception pending and no external source eligible, a start takes the exception. Slot 0 is used for a program exception and slot 1 for a supervisor call. The code word `{ilc[15:0], code[15:0]}` is written to word 0 of the slot.
- R2: The old mask written to word 2 is `cur_mask` with bits 13:12 replaced by `cur_cc`. The old address written to word 3 is `cur_addr` for a program exception, and `cur_addr + ilc` for a supervisor call.
- R3: The new mask is read from word 4 and the new address from word 5. They appear on `new_mask` and `new_addr`, with `new_cc` equal to bits 13:12 of the new mask. `psw_load` pulses for one cycle at that moment.
- R4: `halted` is set when the loaded mask has bit `WAIT_BIT` set. It is cleared by a load whose mask has that bit clear.
- R5: External sources are considered only when `cur_mask[EXT_BIT]` is 1 and no exception is pending. With no eligible source and no exception, a start does nothing: there is no memory access and `busy` stays low.
- R6: Among external sources the stack wins, then the clock comparator, then the CPU timer. They use slot 2. The code word is the request code, or 0x1004 for the clock comparator and 0x1005 for the CPU timer. Word 1 holds the parameter, which is 0 for both timers. Serving a timer clears only its own flag.
- R7: Stacked external requests are served most recent first. External pending stays asserted until the stack is empty.
- R8: An external interruption writes `cpu_id | 0x0D00` to word 6 of slot 2.
- R9: The exception is cleared by its swap. `irq` is high exactly while any source is pending.
- R10: A push onto a full stack marks it overflowed. Taking an external interruption while overflowed sets `err`, makes no memory access and leaves `busy` low.
- R11: `busy` is high from the cycle after `start` until the cycle `psw_load` pulses. The block makes at most one memory access per cycle, and only while `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to select and swap |
| cur_mask | input | W | Current status-word mask |
| cur_addr | input | W | Current instruction address |
| cur_cc | input | 2 | Current condition code |
| cpu_id | input | 16 | CPU number |
| exc_set | input | 1 | Record a pending exception |
| exc_is_svc | input | 1 | 1: supervisor call, 0: program exception |
| exc_code | input | 16 | Exception code |
| exc_ilc | input | 16 | Instruction-length value |
| clkcmp_evt | input | 1 | Clock-comparator event |
| cputmr_evt | input | 1 | CPU-timer event |
| ext_push | input | 1 | Push external request |
| ext_code | input | 16 | External request code |
| ext_param | input | 32 | External request parameter |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, one cycle after read |
| busy | output | 1 | Swap in progress |
| psw_load | output | 1 | New status word loaded |
| new_mask | output | W | Loaded mask |
| new_addr | output | W | Loaded address |
| new_cc | output | 2 | Condition code of loaded mask |
| halted | output | 1 | Wait state entered |
| err | output | 1 | External taken with overflowed stack |
| irq | output | 1 | Any source pending |

## Verification
The bench builds the block with W=32, AW=8, DEPTH=2, BASE=0x10, EXT_BIT=24 and WAIT_BIT=17. The two-entry stack lets a third push reach the overflow path cheaply, and a two-deep push sequence exercises last-in first-out order in full. The bench sweeps all four condition codes for both exception kinds, so every code is inserted into the old mask and every supervisor-call address sum is checked. The small save area allows each slot to be compared word by word against values the bench computes.

// File: rtl/intr_swap_pkg.sv
`timescale 1ns/1ps
package intr_swap_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_PGM, SEL_SVC, SEL_EXTQ, SEL_CLK, SEL_TMR, SEL_ERR
  } sel_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CODE, S_AUX, S_CPU, S_OLDM, S_OLDA, S_RNM, S_RNA, S_LOAD
  } st_e;

  localparam logic [15:0] CODE_CLKCMP = 16'h1004;
  localparam logic [15:0] CODE_CPUTMR = 16'h1005;
  localparam logic [15:0] CPU_TAG     = 16'h0D00;
  localparam int          SLOT_STRIDE = 8;
  localparam int          ENTRY_W     = 48;
endpackage

// File: rtl/intr_lifo.sv
`timescale 1ns/1ps
module intr_lifo #(
  parameter int DEPTH = 8,
  parameter int EW    = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [EW-1:0] din,
  output logic [EW-1:0] top,
  output logic          nonempty,
  output logic          ovf
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] store [DEPTH];
  logic [CW-1:0] cnt;
  logic [IW-1:0] top_i;

  assign top_i    = IW'(cnt - CW'(1));
  assign top      = store[top_i];
  assign nonempty = (cnt != '0);

  always_ff @(posedge clk) begin
    if (push && cnt != CW'(DEPTH)) store[IW'(cnt)] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (push) begin
      if (cnt == CW'(DEPTH)) ovf <= 1'b1;
      else                   cnt <= cnt + CW'(1);
    end else if (pop) begin
      cnt <= cnt - CW'(1);
    end
  end

  a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
    pop |-> (nonempty && !ovf && !push));
endmodule

// File: rtl/intr_arbiter.sv
`timescale 1ns/1ps
module intr_arbiter
  import intr_swap_pkg::*;
(
  input  logic ext_en,
  input  logic exc_pend,
  input  logic exc_is_svc,
  input  logic q_any,
  input  logic q_ovf,
  input  logic clk_f,
  input  logic tmr_f,
  output sel_e sel
);
  logic ext_ok;
  assign ext_ok = ext_en && !exc_pend;

  always_comb begin
    sel = SEL_NONE;
    if (ext_ok && q_any)      sel = q_ovf ? SEL_ERR : SEL_EXTQ;
    else if (ext_ok && clk_f) sel = SEL_CLK;
    else if (ext_ok && tmr_f) sel = SEL_TMR;
    else if (exc_pend)        sel = exc_is_svc ? SEL_SVC : SEL_PGM;
  end
endmodule

// File: rtl/intr_swap.sv
`timescale 1ns/1ps
module intr_swap
  import intr_swap_pkg::*;
#(
  parameter int             W        = 32,
  parameter int             AW       = 8,
  parameter int             DEPTH    = 8,
  parameter logic [AW-1:0]  BASE     = 8'h40,
  parameter int             EXT_BIT  = 24,
  parameter int             WAIT_BIT = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  cur_mask,
  input  logic [W-1:0]  cur_addr,
  input  logic [1:0]    cur_cc,
  input  logic [15:0]   cpu_id,
  input  logic          exc_set,
  input  logic          exc_is_svc,
  input  logic [15:0]   exc_code,
  input  logic [15:0]   exc_ilc,
  input  logic          clkcmp_evt,
  input  logic          cputmr_evt,
  input  logic          ext_push,
  input  logic [15:0]   ext_code,
  input  logic [31:0]   ext_param,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          busy,
  output logic          psw_load,
  output logic [W-1:0]  new_mask,
  output logic [W-1:0]  new_addr,
  output logic [1:0]    new_cc,
  output logic          halted,
  output logic          err,
  output logic          irq
);
  st_e           state;
  sel_e          sel;
  logic          exc_pend_q, exc_svc_q, clk_f, tmr_f, is_ext_q;
  logic [15:0]   exc_code_q, exc_ilc_q;
  logic [1:0]    slot_q;
  logic [W-1:0]  code_w_q, aux_w_q, oldm_q, olda_q, nm_q, oldm_c;
  logic [2:0]    off;
  logic          idle, decide, q_push, q_pop, q_ne, q_ovf;
  logic [ENTRY_W-1:0] q_top;

  assign idle   = (state == S_IDLE);
  assign busy   = !idle;
  assign decide = idle && start;
  assign q_push = ext_push && idle && !start;
  assign q_pop  = decide && (sel == SEL_EXTQ);
  assign irq    = exc_pend_q | q_ne | q_ovf | clk_f | tmr_f;

  intr_lifo #(.DEPTH(DEPTH), .EW(ENTRY_W)) u_lifo (
    .clk(clk), .rst(rst), .push(q_push), .pop(q_pop),
    .din({ext_param, ext_code}), .top(q_top), .nonempty(q_ne), .ovf(q_ovf)
  );

  intr_arbiter u_arb (
    .ext_en(cur_mask[EXT_BIT]), .exc_pend(exc_pend_q), .exc_is_svc(exc_svc_q),
    .q_any(q_ne | q_ovf), .q_ovf(q_ovf), .clk_f(clk_f), .tmr_f(tmr_f), .sel(sel)
  );

  always_comb begin
    oldm_c        = cur_mask;
    oldm_c[13:12] = cur_cc;
  end

  // exception slot and timer flags
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_pend_q <= 1'b0;
      exc_svc_q  <= 1'b0;
      exc_code_q <= '0;
      exc_ilc_q  <= '0;
      clk_f      <= 1'b0;
      tmr_f      <= 1'b0;
    end else begin
      if (exc_set && idle && !start) begin
        exc_pend_q <= 1'b1;
        exc_svc_q  <= exc_is_svc;
        exc_code_q <= exc_code;
        exc_ilc_q  <= exc_ilc;
      end else if (state == S_LOAD && !is_ext_q) begin
        exc_pend_q <= 1'b0;
      end
      if (clkcmp_evt)                  clk_f <= 1'b1;
      else if (decide && sel == SEL_CLK) clk_f <= 1'b0;
      if (cputmr_evt)                  tmr_f <= 1'b1;
      else if (decide && sel == SEL_TMR) tmr_f <= 1'b0;
    end
  end

  // swap sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      slot_q   <= '0;
      is_ext_q <= 1'b0;
      code_w_q <= '0;
      aux_w_q  <= '0;
      oldm_q   <= '0;
      olda_q   <= '0;
      nm_q     <= '0;
      new_mask <= '0;
      new_addr <= '0;
      new_cc   <= '0;
      halted   <= 1'b0;
      err      <= 1'b0;
      psw_load <= 1'b0;
    end else begin
      psw_load <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          oldm_q  <= oldm_c;
          olda_q  <= cur_addr;
          aux_w_q <= '0;
          case (sel)
            SEL_PGM: begin
              slot_q <= 2'd0; is_ext_q <= 1'b0;
              code_w_q <= W'({exc_ilc_q, exc_code_q});
              state <= S_CODE;
            end
            SEL_SVC: begin
              slot_q <= 2'd1; is_ext_q <= 1'b0;
              code_w_q <= W'({exc_ilc_q, exc_code_q});
              olda_q <= cur_addr + W'(exc_ilc_q);
              state <= S_CODE;
            end
            SEL_EXTQ: begin
              slot_q <= 2'd2; is_ext_q <= 1'b1;
              code_w_q <= W'(q_top[15:0]);
              aux_w_q <= W'(q_top[ENTRY_W-1:16]);
              state <= S_CODE;
            end
            SEL_CLK: begin
              slot_q <= 2'd2; is_ext_q <= 1'b1;
              code_w_q <= W'(CODE_CLKCMP);
              state <= S_CODE;
            end
            SEL_TMR: begin
              slot_q <= 2'd2; is_ext_q <= 1'b1;
              code_w_q <= W'(CODE_CPUTMR);
              state <= S_CODE;
            end
            SEL_ERR:  err <= 1'b1;
            default:  ;
          endcase
        end
        S_CODE: state <= is_ext_q ? S_AUX : S_OLDM;
        S_AUX:  state <= S_CPU;
        S_CPU:  state <= S_OLDM;
        S_OLDM: state <= S_OLDA;
        S_OLDA: state <= S_RNM;
        S_RNM:  state <= S_RNA;
        S_RNA: begin
          nm_q  <= mem_rdata;
          state <= S_LOAD;
        end
        S_LOAD: begin
          new_mask <= nm_q;
          new_addr <= mem_rdata;
          new_cc   <= nm_q[13:12];
          halted   <= nm_q[WAIT_BIT];
          psw_load <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // one memory access per state
  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    off       = 3'd0;
    case (state)
      S_CODE: begin mem_we = 1'b1; off = 3'd0; mem_wdata = code_w_q; end
      S_AUX:  begin mem_we = 1'b1; off = 3'd1; mem_wdata = aux_w_q; end
      S_CPU:  begin mem_we = 1'b1; off = 3'd6; mem_wdata = W'(cpu_id | CPU_TAG); end
      S_OLDM: begin mem_we = 1'b1; off = 3'd2; mem_wdata = oldm_q; end
      S_OLDA: begin mem_we = 1'b1; off = 3'd3; mem_wdata = olda_q; end
      S_RNM:  begin mem_re = 1'b1; off = 3'd4; end
      S_RNA:  begin mem_re = 1'b1; off = 3'd5; end
      default: ;
    endcase
    mem_addr = BASE + AW'(slot_q) * AW'(SLOT_STRIDE) + AW'(off);
  end

  a_r11_single_access: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !mem_re);
  a_r11_access_in_busy: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> busy);
  a_r11_busy_ends_at_load: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> psw_load);
  a_r3_cc_of_loaded: assert property (@(posedge clk) disable iff (rst)
    psw_load |-> (new_cc == new_mask[13:12]));
  a_r4_halt_of_loaded: assert property (@(posedge clk) disable iff (rst)
    psw_load |-> (halted == new_mask[WAIT_BIT]));
  a_r5_ext_gated: assert property (@(posedge clk) disable iff (rst)
    (decide && (sel == SEL_EXTQ || sel == SEL_CLK || sel == SEL_TMR))
      |-> (cur_mask[EXT_BIT] && !exc_pend_q));
  a_r10_err_no_swap: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !busy);
endmodule

// File: tb/sim_intr_swap.sv
`timescale 1ns/1ps
module sim_intr_swap;
  localparam logic [7:0] PB = 8'h10, SB = 8'h18, EB = 8'h20;

  logic clk = 0, rst = 1, start = 0;
  logic [31:0] cur_mask = 0, cur_addr = 0;
  logic [1:0]  cur_cc = 0;
  logic [15:0] cpu_id = 16'h0003;
  logic exc_set = 0, exc_is_svc = 0, clkcmp_evt = 0, cputmr_evt = 0, ext_push = 0;
  logic [15:0] exc_code = 0, exc_ilc = 0, ext_code = 0;
  logic [31:0] ext_param = 0;
  logic mem_we, mem_re, busy, psw_load, halted, err, irq;
  logic [7:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata, new_mask, new_addr;
  logic [1:0]  new_cc;
  logic [31:0] mem [256];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  intr_swap #(.W(32), .AW(8), .DEPTH(2), .BASE(8'h10), .EXT_BIT(24), .WAIT_BIT(17)) u0 (
    .clk(clk), .rst(rst), .start(start), .cur_mask(cur_mask), .cur_addr(cur_addr),
    .cur_cc(cur_cc), .cpu_id(cpu_id), .exc_set(exc_set), .exc_is_svc(exc_is_svc),
    .exc_code(exc_code), .exc_ilc(exc_ilc), .clkcmp_evt(clkcmp_evt),
    .cputmr_evt(cputmr_evt), .ext_push(ext_push), .ext_code(ext_code),
    .ext_param(ext_param), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .psw_load(psw_load),
    .new_mask(new_mask), .new_addr(new_addr), .new_cc(new_cc), .halted(halted),
    .err(err), .irq(irq)
  );

  always @(posedge clk) begin
    if (rst) begin
      mem[PB+4] <= 32'h0000_2000; mem[PB+5] <= 32'h0000_A000;
      mem[SB+4] <= 32'h0100_1000; mem[SB+5] <= 32'h0000_B000;
      mem[EB+4] <= 32'h0002_3000; mem[EB+5] <= 32'h0000_C000;
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
    end
  end

  function automatic logic [31:0] om(input logic [31:0] m, input logic [1:0] cc);
    om = (m & ~32'h3000) | (32'(cc) << 12);
  endfunction

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic pulse_exc(input bit svc, input logic [15:0] c, input logic [15:0] l);
    @(negedge clk); exc_set = 1; exc_is_svc = svc; exc_code = c; exc_ilc = l;
    @(negedge clk); exc_set = 0;
  endtask

  task automatic push(input logic [15:0] c, input logic [31:0] p);
    @(negedge clk); ext_push = 1; ext_code = c; ext_param = p;
    @(negedge clk); ext_push = 0;
  endtask

  task automatic evt(input bit cc, input bit ct);
    @(negedge clk); clkcmp_evt = cc; cputmr_evt = ct;
    @(negedge clk); clkcmp_evt = 0; cputmr_evt = 0;
  endtask

  task automatic go();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int n = 0; n < 50 && busy; n++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("reset busy R11", busy, 0);
    chk("reset irq R9", irq, 0);
    chk("reset halted R4", halted, 0);
    chk("reset err R10", err, 0);

    // R1 R2 R3: both exception kinds across all condition codes
    for (int k = 0; k < 2; k++) begin
      for (int cc = 0; cc < 4; cc++) begin
        logic [7:0]  b;
        logic [15:0] c, l;
        b = (k == 1) ? SB : PB;
        c = 16'(16'h10 + cc + 4 * k);
        l = 16'(2 * (cc + 1));
        cur_mask = 32'h0000_3F07 | (32'(cc) << 20);
        cur_addr = 32'h1000 + 32'(cc * 16);
        cur_cc = 2'(cc);
        pulse_exc(k == 1, c, l);
        chk("R9 irq set", irq, 1);
        go();
        chk("R1 code word", mem[b], {l, c});
        chk("R2 old mask", mem[b+2], om(cur_mask, cur_cc));
        chk("R2 old addr", mem[b+3], (k == 1) ? cur_addr + 32'(l) : cur_addr);
        chk("R3 new mask", new_mask, (k == 1) ? 32'h0100_1000 : 32'h0000_2000);
        chk("R3 new addr", new_addr, (k == 1) ? 32'h0000_B000 : 32'h0000_A000);
        chk("R3 new cc", 32'(new_cc), (k == 1) ? 1 : 2);
        chk("R11 load pulse", psw_load, 1);
        chk("R9 irq clear", irq, 0);
        chk("R4 no halt", halted, 0);
      end
    end

    // R5: exception beats queued external
    cur_mask = 32'h0100_0000; cur_cc = 2'd1; cur_addr = 32'h4000;
    snap = mem[EB];
    push(16'h0040, 32'h1234);
    pulse_exc(0, 16'h0055, 16'd4);
    go();
    chk("R5 exception first", mem[PB], {16'd4, 16'h0055});
    chk("R5 ext untouched", mem[EB], snap);
    chk("R9 still pending", irq, 1);
    go();
    chk("R6 ext code", mem[EB], 32'h40);
    chk("R6 ext param", mem[EB+1], 32'h1234);
    chk("R8 cpu word", mem[EB+6], 32'h0000_0D03);
    chk("R2 ext old mask", mem[EB+2], om(cur_mask, cur_cc));
    chk("R4 halted", halted, 1);
    chk("R3 ext cc", 32'(new_cc), 3);
    chk("R9 drained", irq, 0);

    // R5: masked timers are not taken
    cur_mask = 32'h0;
    evt(1, 0);
    snap = mem[EB];
    go();
    chk("R5 masked no write", mem[EB], snap);
    chk("R5 masked no load", psw_load, 0);
    chk("R5 masked pending", irq, 1);
    cur_mask = 32'h0100_0000;
    go();
    chk("R6 clock code", mem[EB], 32'h1004);
    chk("R6 clock param", mem[EB+1], 0);
    chk("R9 clock cleared", irq, 0);

    // R6: full priority chain
    evt(1, 1);
    push(16'h0077, 32'h99);
    go();
    chk("R6 queue first", mem[EB], 32'h77);
    go();
    chk("R6 clock second", mem[EB], 32'h1004);
    chk("R6 timer pending", irq, 1);
    go();
    chk("R6 timer third", mem[EB], 32'h1005);
    chk("R6 timer param", mem[EB+1], 0);
    chk("R9 all clear", irq, 0);

    // R7: last in first out
    push(16'h00A1, 32'h1);
    push(16'h00B2, 32'h2);
    go();
    chk("R7 newest first", mem[EB], 32'hB2);
    chk("R7 newest param", mem[EB+1], 32'h2);
    chk("R7 still pending", irq, 1);
    go();
    chk("R7 oldest last", mem[EB], 32'hA1);
    chk("R7 empty", irq, 0);

    // R4: halt released by a load without wait bit
    cur_mask = 32'h0;
    pulse_exc(0, 16'h0009, 16'd2);
    go();
    chk("R4 halt cleared", halted, 0);

    // R10: overflow
    cur_mask = 32'h0100_0000;
    push(16'h1, 32'h1);
    push(16'h2, 32'h2);
    push(16'h3, 32'h3);
    snap = mem[EB];
    go();
    chk("R10 err", err, 1);
    chk("R10 no busy", busy, 0);
    chk("R10 no write", mem[EB], snap);
    chk("R10 pending", irq, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule